// File: doc/BRIEF.md
# External Clock Bypass Request Controller

This controller decides when the clock sources must hand over to an external bypass clock, and it runs the request and acknowledge exchange with the analog clock source. A bypass is wanted for one of two reasons. The first is a lifecycle request. The second is a software selection, which is honoured only while the lifecycle debug qualifier is On. The result is registered and sent to the analog side as a request.

The analog acknowledge is asynchronous to the local clock. It passes through a two-flop synchronizer before any logic uses it. Once synchronized, it is returned to the lifecycle side while that side is still requesting. It also produces a step-down command that tells the io clock dividers to undo one divide-by-2. Scan mode vetoes that command.

All control codes are 4 bits wide. On is `4'b1010` and Off is `4'b0101`. Any other value counts as not On. Software reaches the block through a write strobe with a one-bit address:
- Address 0 is the selection register.
- Address 1 is the write-enable register.

Both registers are always visible on read-back ports.

Top module: `extclk_bypass_ctrl`

## Requirements
- R1: When `lc_byp_req_i` equals On (`4'b1010`), `ana_req_o` is On after the next rising clock edge.
- R2: When the selection register holds On and `lc_dbg_en_i` equals On, `ana_req_o` is On after the next rising edge.
- R3: When neither R1 nor R2 applies, `ana_req_o` is Off (`4'b0101`) after the next rising edge. This holds in particular when the selection is On but the debug qualifier is Off or any other code.
- R4: Any input code other than `4'b1010` counts as not On. Every output carries only the On or Off code.
- R5: The write-enable register (address 1, read on `rd_wen_o`) is 1 after reset. A write with `wr_data_i[0]`=0 clears it. It then stays 0 until reset, even if 1 is written.
- R6: While the write-enable register is 0, writes to the selection register (address 0) are dropped, and `rd_sel_o` keeps its value.
- R7: The selection register resets to Off. While writes are enabled, it reads back exactly the 4-bit value last written to it, invalid codes included.
- R8: `step_down_o` turns On at the second rising edge after `ana_ack_i` becomes On, because the acknowledge passes through a two-flop synchronizer.
- R9: While `scan_mode_i` equals On, `step_down_o` is Off. The veto acts without a clock edge.
- R10: `lc_ack_o` is On only while the synchronized acknowledge is On and `lc_byp_req_i` is On. Otherwise it is Off.
- R11: During and just after reset, `ana_req_o`, `lc_ack_o` and `step_down_o` are Off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = selection register, 1 = write-enable register |
| wr_data_i | input | 4 | Write data |
| rd_sel_o | output | 4 | Selection register read-back |
| rd_wen_o | output | 1 | Write-enable register read-back |
| lc_byp_req_i | input | 4 | Lifecycle bypass request code |
| lc_dbg_en_i | input | 4 | Lifecycle debug qualifier code |
| scan_mode_i | input | 4 | Scan mode code |
| ana_ack_i | input | 4 | Asynchronous acknowledge from the analog clock source |
| ana_req_o | output | 4 | Bypass request to the analog clock source |
| lc_ack_o | output | 4 | Acknowledge to the lifecycle side |
| step_down_o | output | 4 | Divider step-down command |

## Verification
Each result has a fixed latency, and every check samples at the falling edge that follows it:
- **Register writes** show on the read-back ports one edge after the strobe.
- **The analog request** follows its inputs by one further edge, so after a write it is sampled two edges later.
- **The step-down command and the lifecycle acknowledge** rise on the second edge after the analog acknowledge changes. The bench checks both the falling edge in between, which must still read Off, and the one after, which must read On.
- **The scan-mode veto and the lifecycle-request gating** act without a clock edge. They are checked a short delay after the input moves, with no edge in between.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int unsigned CodeW = 4;
  typedef logic [CodeW-1:0] code_t;
  localparam code_t CodeOn  = 4'b1010;
  localparam code_t CodeOff = 4'b0101;

  function automatic logic is_on(code_t c);
    return c == CodeOn;
  endfunction

  function automatic code_t to_code(logic b);
    return b ? CodeOn : CodeOff;
  endfunction
endpackage

// File: rtl/byp_sel_reg.sv
module byp_sel_reg
  import byp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  wr_addr_i,
  input  code_t wr_data_i,
  output code_t sel_o,
  output logic  wen_o
);
  code_t sel_d, sel_q;
  logic  wen_d, wen_q;
  logic  sel_we, wen_clr;

  always_comb begin
    sel_we  = wr_en_i && !wr_addr_i && wen_q;
    wen_clr = wr_en_i && wr_addr_i && !wr_data_i[0];
    sel_d   = sel_we ? wr_data_i : sel_q;
    wen_d   = wen_clr ? 1'b0 : wen_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= CodeOff;
      wen_q <= 1'b1;
    end else begin
      sel_q <= sel_d;
      wen_q <= wen_d;
    end
  end

  assign sel_o = sel_q;
  assign wen_o = wen_q;

  // R6: locked selection register ignores writes
  a_r6_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wen_q && wr_en_i && !wr_addr_i) |=> $stable(sel_q));
  // R5: once cleared, write enable stays cleared
  a_r5_wen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> !wen_q);
  // R7: enabled write lands exactly
  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_q && wr_en_i && !wr_addr_i) |=> sel_q == $past(wr_data_i));
endmodule

// File: rtl/byp_sync.sv
module byp_sync
  import byp_pkg::*;
#(
  parameter int unsigned Stages = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t d_i,
  output code_t q_o
);
  code_t stage_q [Stages];

  for (genvar s = 0; s < Stages; s++) begin : g_stage
    code_t stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= CodeOff;
      else         stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[Stages-1];
endmodule

// File: rtl/extclk_bypass_ctrl.sv
module extclk_bypass_ctrl
  import byp_pkg::*;
#(
  parameter int unsigned SyncStages = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_addr_i,
  input  logic [CodeW-1:0]     wr_data_i,
  output logic [CodeW-1:0]     rd_sel_o,
  output logic                 rd_wen_o,
  input  logic [CodeW-1:0]     lc_byp_req_i,
  input  logic [CodeW-1:0]     lc_dbg_en_i,
  input  logic [CodeW-1:0]     scan_mode_i,
  input  logic [CodeW-1:0]     ana_ack_i,
  output logic [CodeW-1:0]     ana_req_o,
  output logic [CodeW-1:0]     lc_ack_o,
  output logic [CodeW-1:0]     step_down_o
);
  code_t sel_q;
  code_t ack_sync;
  logic  req_d, req_q;

  byp_sel_reg u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sel_o     (sel_q),
    .wen_o     (rd_wen_o)
  );

  byp_sync #(.Stages(SyncStages)) u_ack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ana_ack_i),
    .q_o    (ack_sync)
  );

  always_comb begin
    req_d = is_on(lc_byp_req_i) || (is_on(sel_q) && is_on(lc_dbg_en_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign rd_sel_o    = sel_q;
  assign ana_req_o   = to_code(req_q);
  assign lc_ack_o    = to_code(is_on(ack_sync) && is_on(lc_byp_req_i));
  assign step_down_o = to_code(is_on(ack_sync) && !is_on(scan_mode_i));

  // R1: lifecycle request forces bypass
  a_r1_lc_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_on(lc_byp_req_i) |=> ana_req_o == CodeOn);
  // R2: qualified software selection forces bypass
  a_r2_sw_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_o == CodeOn && lc_dbg_en_i == CodeOn) |=> ana_req_o == CodeOn);
  // R3: no cause, no request
  a_r3_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_byp_req_i != CodeOn && !(rd_sel_o == CodeOn && lc_dbg_en_i == CodeOn))
      |=> ana_req_o == CodeOff);
  // R4: outputs carry only legal codes
  a_r4_legal_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ana_req_o == CodeOn || ana_req_o == CodeOff) &&
    (step_down_o == CodeOn || step_down_o == CodeOff) &&
    (lc_ack_o == CodeOn || lc_ack_o == CodeOff));
  // R9: scan mode vetoes step-down
  a_r9_scan_veto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_mode_i == CodeOn |-> step_down_o == CodeOff);
  // R10: lifecycle acknowledge needs a lifecycle request
  a_r10_lc_ack_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_byp_req_i != CodeOn |-> lc_ack_o == CodeOff);
endmodule

// File: tb/tb_extclk_bypass_ctrl.sv
module tb_extclk_bypass_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] ON  = 4'b1010;
  localparam logic [3:0] OFF = 4'b0101;
  localparam logic [3:0] BAD = 4'b1011;
  localparam int NVEC = 8;
  // each entry: {lc_req, dbg_en, sel_value, expected ana_req}
  localparam logic [15:0] VEC [NVEC] = '{
    {ON,  OFF, OFF, ON },
    {OFF, ON,  ON,  ON },
    {OFF, OFF, ON,  OFF},
    {OFF, 4'b0000, ON, OFF},
    {BAD, OFF, OFF, OFF},
    {OFF, ON,  BAD, OFF},
    {ON,  ON,  ON,  ON },
    {OFF, ON,  OFF, OFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [3:0] wr_data = 4'b0000;
  logic [3:0] rd_sel;
  logic rd_wen;
  logic [3:0] lc_req = OFF, dbg = OFF, scan = OFF, ack = OFF;
  logic [3:0] ana_req, lc_ack, step_down;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extclk_bypass_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_sel_o(rd_sel), .rd_wen_o(rd_wen),
    .lc_byp_req_i(lc_req), .lc_dbg_en_i(dbg), .scan_mode_i(scan),
    .ana_ack_i(ack), .ana_req_o(ana_req), .lc_ack_o(lc_ack),
    .step_down_o(step_down)
  );

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic write(logic addr, logic [3:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    #(CLK_PERIOD * 2 + 1);
    check("R11 req in reset", ana_req, OFF);
    check("R11 lc_ack in reset", lc_ack, OFF);
    check("R11 step in reset", step_down, OFF);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11 req after reset", ana_req, OFF);
    check("R7 sel reset Off", rd_sel, OFF);
    check("R5 wen reset 1", {3'b0, rd_wen}, 4'b0001);

    // table walk: R1 R2 R3 R4 R7
    for (int i = 0; i < NVEC; i++) begin
      write(1'b0, VEC[i][7:4]);
      lc_req = VEC[i][15:12]; dbg = VEC[i][11:8];
      check("R7 readback", rd_sel, VEC[i][7:4]);
      @(negedge clk); @(negedge clk);
      check("R1/R2/R3/R4 vector", ana_req, VEC[i][3:0]);
    end
    lc_req = OFF; dbg = OFF;

    // R8 synchronizer latency, R10 lc ack
    lc_req = ON;
    @(negedge clk); ack = ON;
    @(negedge clk);
    check("R8 step after one edge", step_down, OFF);
    check("R10 lc_ack after one edge", lc_ack, OFF);
    @(negedge clk);
    check("R8 step after two edges", step_down, ON);
    check("R10 lc_ack with request", lc_ack, ON);
    lc_req = OFF; #1;
    check("R10 lc_ack without request", lc_ack, OFF);
    lc_req = BAD; #1;
    check("R4 R10 invalid request code", lc_ack, OFF);
    // R9 scan veto, no clock edge needed
    scan = ON; #1;
    check("R9 scan veto", step_down, OFF);
    scan = BAD; #1;
    check("R9 R4 invalid scan code", step_down, ON);
    scan = OFF;
    @(negedge clk); ack = OFF;
    @(negedge clk); @(negedge clk);
    check("R8 step drops", step_down, OFF);

    // R5 R6 lock
    write(1'b0, ON);
    check("R7 sel On", rd_sel, ON);
    write(1'b1, 4'b0000);
    check("R5 wen cleared", {3'b0, rd_wen}, 4'b0000);
    write(1'b0, OFF);
    check("R6 locked write dropped", rd_sel, ON);
    write(1'b1, 4'b0001);
    check("R5 wen stays cleared", {3'b0, rd_wen}, 4'b0000);
    dbg = ON;
    @(negedge clk); @(negedge clk);
    check("R2 locked selection still requests", ana_req, ON);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule